// File: doc/BRIEF.md
# Priority-Based Reference Selector

This block decides which of several reference clock inputs (two by default) feeds a downstream timing loop. Each input carries a raw fault flag from an external monitor. A per-input qualification counter, advanced by a millisecond tick, must see the input fault-free for a programmed number of ticks before that input counts as usable. Any fault disqualifies the input at once and restarts its count.

Among the usable inputs the block picks one from a programmable priority code per input, where a numerically lower code means a more preferred input. It works in one of three styles: operator choice (manual), automatic with return to a better input (revertive), or automatic that stays put while the current input is healthy (non-revertive). It drives the chosen index, a one-cycle pulse on every change of that index, and a holdover request while no usable input is selected.

Top module: `ref_selector`

## Requirements
- R1: While reset is asserted and after its release, until an input qualifies, `active_ref` is 0, `holdover_req` is 1 and `switch_pulse` is 0.
- R2: An input becomes usable only after its fault flag has stayed low for `ref_period` millisecond ticks; before that count is reached it is not usable.
- R3: A fault, even for one cycle, makes the input unusable on the next clock and restarts its tick count from zero.
- R4: In the automatic modes (`sel_mode` 1 = revertive, 2 = non-revertive), when the active input becomes unusable the block moves to the usable input with the lowest priority code.
- R5: When leaving holdover with several usable inputs of equal code, the lower input index is chosen.
- R6: Equal priority codes never cause a switch away from a usable active input.
- R7: In revertive mode the block moves to a usable input whose code is strictly lower than that of the active input.
- R8: In non-revertive mode the block stays on a usable active input even when an input with a lower code becomes usable.
- R9: In non-revertive mode the block switches when the active input becomes unusable and another is usable.
- R10: In manual mode (`sel_mode` 0) `active_ref` follows `manual_sel` one clock later whether or not that input is usable, and `holdover_req` is 1 exactly when the selected input is unusable.
- R11: In the automatic modes, when no input is usable, `holdover_req` is 1 and `active_ref` keeps its previous value.
- R12: `switch_pulse` is high for exactly one clock in the cycle `active_ref` takes a new value, and never otherwise.
- R13: `sel_mode` code 3 behaves as manual mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| ref_fault | input | NREF | Raw fault flag per input, 1 = faulted |
| ref_period | input | NREF*PER_W | Qualification period per input in ticks, input i at bits [i*PER_W +: PER_W] |
| ref_prio | input | NREF*PRIO_W | Priority code per input, lower is preferred, input i at bits [i*PRIO_W +: PRIO_W] |
| sel_mode | input | 2 | 0 manual, 1 automatic revertive, 2 automatic non-revertive, 3 manual |
| manual_sel | input | IDX_W | Input index used in manual mode |
| active_ref | output | IDX_W | Index of the selected input |
| switch_pulse | output | 1 | One-cycle pulse when `active_ref` changes |
| holdover_req | output | 1 | Selected input unusable or none usable |

## Verification
The bench builds the block with its default parameters (two inputs, 3-bit priority codes, 16-bit periods) and programs periods of only three to five ticks, with a tick every four clocks, so qualification, requalification and restart after a glitch all happen within a few dozen cycles. Equal periods on both inputs make them qualify in the same cycle, which brings the index tie-break out of holdover within reach, and rewriting priority codes while running exercises the equal-code no-switch rule.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;

  typedef enum logic [1:0] {
    SEL_MANUAL      = 2'd0,
    SEL_AUTO_REVERT = 2'd1,
    SEL_AUTO_STAY   = 2'd2,
    SEL_MANUAL_ALT  = 2'd3
  } sel_mode_e;

endpackage

// File: rtl/ref_valid_timer.sv
module ref_valid_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             fault,
  input  logic [PER_W-1:0] period,
  output logic             valid
);

  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             val_q, val_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    val_d  = val_q;
    cnt_en = 1'b0;
    if (fault) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
      val_d  = 1'b0;
    end else if (!val_q) begin
      cnt_en = 1'b1;
      if (cnt_q >= period) begin
        val_d = 1'b1;
      end else if (tick) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      val_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      val_q <= val_d;
    end
  end

  assign valid = val_q;

  p_fault_drops_valid_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !val_q);

  p_rise_needs_clean_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(val_q) |-> !$past(fault));

endmodule

// File: rtl/ref_prio_pick.sv
module ref_prio_pick #(
  parameter int NREF   = 2,
  parameter int PRIO_W = 3,
  parameter int IDX_W  = 1
) (
  input  logic [NREF-1:0]        valid,
  input  logic [NREF*PRIO_W-1:0] prio,
  output logic [IDX_W-1:0]       best_idx,
  output logic [PRIO_W-1:0]      best_prio,
  output logic                   any_valid
);

  always_comb begin
    best_idx  = '0;
    best_prio = '1;
    any_valid = 1'b0;
    // walk from the top index down so a lower index wins on equal codes
    for (int i = NREF - 1; i >= 0; i--) begin
      if (valid[i] && (!any_valid || (prio[i*PRIO_W +: PRIO_W] <= best_prio))) begin
        best_idx  = IDX_W'(i);
        best_prio = prio[i*PRIO_W +: PRIO_W];
        any_valid = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ref_arbiter.sv
module ref_arbiter
  import ref_sel_pkg::*;
#(
  parameter int NREF   = 2,
  parameter int PRIO_W = 3,
  parameter int IDX_W  = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  sel_mode_e              mode,
  input  logic [IDX_W-1:0]       manual_sel,
  input  logic [NREF-1:0]        valid,
  input  logic [NREF*PRIO_W-1:0] prio,
  input  logic [IDX_W-1:0]       best_idx,
  input  logic [PRIO_W-1:0]      best_prio,
  input  logic                   any_valid,
  output logic [IDX_W-1:0]       active,
  output logic                   hold,
  output logic                   sw
);

  logic [IDX_W-1:0]  act_q, act_d;
  logic              hold_q, hold_d;
  logic              sw_q, sw_d;
  logic [PRIO_W-1:0] act_prio;
  logic              act_valid;
  logic              sel_in_range;
  logic              is_auto;

  assign is_auto      = (mode == SEL_AUTO_REVERT) || (mode == SEL_AUTO_STAY);
  assign sel_in_range = ({1'b0, manual_sel} < (IDX_W + 1)'(NREF));
  assign act_valid    = valid[act_q];

  always_comb begin
    act_prio = '1;
    for (int i = 0; i < NREF; i++) begin
      if (act_q == IDX_W'(i)) act_prio = prio[i*PRIO_W +: PRIO_W];
    end
  end

  always_comb begin
    act_d  = act_q;
    hold_d = hold_q;
    unique case (mode)
      SEL_AUTO_REVERT: begin
        if (!any_valid) begin
          hold_d = 1'b1;
        end else begin
          hold_d = 1'b0;
          if (hold_q || !act_valid || (best_prio < act_prio)) act_d = best_idx;
        end
      end
      SEL_AUTO_STAY: begin
        if (!any_valid) begin
          hold_d = 1'b1;
        end else begin
          hold_d = 1'b0;
          if (hold_q || !act_valid) act_d = best_idx;
        end
      end
      default: begin
        if (sel_in_range) act_d = manual_sel;
        hold_d = !valid[act_d];
      end
    endcase
    sw_d = (act_d != act_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      hold_q <= 1'b1;
      sw_q   <= 1'b0;
    end else begin
      act_q  <= act_d;
      hold_q <= hold_d;
      sw_q   <= sw_d;
    end
  end

  assign active = act_q;
  assign hold   = hold_q;
  assign sw     = sw_q;

  p_pulse_on_change_r12 : assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != $past(act_q)) |-> sw_q);

  p_pulse_only_change_r12 : assert property (@(posedge clk) disable iff (!rst_n)
    sw_q |-> (act_q != $past(act_q)));

  p_hold_when_none_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    (is_auto && (valid == '0)) |=> (hold_q && $stable(act_q)));

  p_manual_follow_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    (!is_auto && sel_in_range) |=> (act_q == $past(manual_sel)));

endmodule

// File: rtl/ref_selector.sv
module ref_selector
  import ref_sel_pkg::*;
#(
  parameter int NREF   = 2,
  parameter int PRIO_W = 3,
  parameter int PER_W  = 16,
  localparam int IDX_W = (NREF > 1) ? $clog2(NREF) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ms_tick,
  input  logic [NREF-1:0]        ref_fault,
  input  logic [NREF*PER_W-1:0]  ref_period,
  input  logic [NREF*PRIO_W-1:0] ref_prio,
  input  logic [1:0]             sel_mode,
  input  logic [IDX_W-1:0]       manual_sel,
  output logic [IDX_W-1:0]       active_ref,
  output logic                   switch_pulse,
  output logic                   holdover_req
);

  logic [NREF-1:0]   ref_ok;
  logic [IDX_W-1:0]  best_idx;
  logic [PRIO_W-1:0] best_prio;
  logic              any_ok;
  sel_mode_e         mode;

  assign mode = sel_mode_e'(sel_mode);

  for (genvar g = 0; g < NREF; g++) begin : g_qual
    ref_valid_timer #(
      .PER_W (PER_W)
    ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (ms_tick),
      .fault  (ref_fault[g]),
      .period (ref_period[g*PER_W +: PER_W]),
      .valid  (ref_ok[g])
    );
  end

  ref_prio_pick #(
    .NREF   (NREF),
    .PRIO_W (PRIO_W),
    .IDX_W  (IDX_W)
  ) u_pick (
    .valid     (ref_ok),
    .prio      (ref_prio),
    .best_idx  (best_idx),
    .best_prio (best_prio),
    .any_valid (any_ok)
  );

  ref_arbiter #(
    .NREF   (NREF),
    .PRIO_W (PRIO_W),
    .IDX_W  (IDX_W)
  ) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .manual_sel (manual_sel),
    .valid      (ref_ok),
    .prio       (ref_prio),
    .best_idx   (best_idx),
    .best_prio  (best_prio),
    .any_valid  (any_ok),
    .active     (active_ref),
    .hold       (holdover_req),
    .sw         (switch_pulse)
  );

endmodule

// File: tb/sim_ref_selector.sv
module sim_ref_selector;

  localparam int CLK_P    = 10;
  localparam int TICK_DIV = 4;
  localparam int NREF     = 2;
  localparam int PRIO_W   = 3;
  localparam int PER_W    = 16;

  logic                   clk;
  logic                   rst_n;
  logic                   ms_tick;
  logic [NREF-1:0]        ref_fault;
  logic [NREF*PER_W-1:0]  ref_period;
  logic [NREF*PRIO_W-1:0] ref_prio;
  logic [1:0]             sel_mode;
  logic [0:0]             manual_sel;
  logic [0:0]             active_ref;
  logic                   switch_pulse;
  logic                   holdover_req;

  ref_selector #(.NREF(NREF), .PRIO_W(PRIO_W), .PER_W(PER_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .ref_fault(ref_fault),
    .ref_period(ref_period), .ref_prio(ref_prio), .sel_mode(sel_mode),
    .manual_sel(manual_sel), .active_ref(active_ref),
    .switch_pulse(switch_pulse), .holdover_req(holdover_req)
  );

  typedef struct {
    int    kind;   // 0 state, 1 pulse count
    int    a;
    int    h;
    int    n;
    string tag;
  } item_t;

  item_t sbq[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  int    n_pulse = 0;
  int    exp_np = 0;
  int    tdiv = 0;

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      tdiv    <= 0;
      ms_tick <= 1'b0;
    end else begin
      tdiv    <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
      ms_tick <= (tdiv == TICK_DIV - 1);
    end
  end

  always @(posedge clk) if (rst_n && switch_pulse) n_pulse <= n_pulse + 1;

  // monitor: pops expected items and compares away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        n_chk++;
        if (it.kind == 0) begin
          if (int'(active_ref) != it.a || int'(holdover_req) != it.h) begin
            n_fail++;
            $display("FAIL %s: active=%0d hold=%0d expected active=%0d hold=%0d",
                     it.tag, active_ref, holdover_req, it.a, it.h);
          end
        end else begin
          if (n_pulse != it.n) begin
            n_fail++;
            $display("FAIL %s: switch pulses=%0d expected %0d", it.tag, n_pulse, it.n);
          end
        end
      end
    end
  end

  task automatic expect_st(input int a, input int h, input string tag);
    item_t it;
    it.kind = 0; it.a = a; it.h = h; it.n = 0; it.tag = tag;
    sbq.push_back(it);
    wait (sbq.size() == 0);
  endtask

  task automatic expect_np(input int n, input string tag);
    item_t it;
    it.kind = 1; it.a = 0; it.h = 0; it.n = n; it.tag = tag;
    sbq.push_back(it);
    wait (sbq.size() == 0);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic fault_blip(input logic [NREF-1:0] m);
    ref_fault = ref_fault | m;
    cyc(1);
    ref_fault = ref_fault & ~m;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    rst_n      = 1'b0;
    ref_fault  = 2'b11;
    ref_period = {16'd5, 16'd3};
    ref_prio   = {3'd1, 3'd2};
    sel_mode   = 2'd1;
    manual_sel = 1'b0;
    cyc(3);
    expect_st(0, 1, "R1 in reset");
    rst_n = 1'b1;
    cyc(2);
    expect_st(0, 1, "R1 after release");
    expect_np(0, "R1 no pulse");

    ref_fault[0] = 1'b0;
    cyc(8);
    expect_st(0, 1, "R2 before period");
    cyc(16);
    expect_st(0, 0, "R2 qualified");

    fault_blip(2'b01);
    cyc(2);
    expect_st(0, 1, "R3 fault drops usable");
    cyc(4);
    expect_st(0, 1, "R3 count restarted");
    cyc(20);
    expect_st(0, 0, "R3 requalified");

    ref_fault[1] = 1'b0;
    cyc(30);
    exp_np = 1;
    expect_st(1, 0, "R7 move to lower code");
    expect_np(exp_np, "R12 one pulse");

    fault_blip(2'b10);
    cyc(3);
    exp_np = 2;
    expect_st(0, 0, "R4 fallback to usable");
    cyc(30);
    exp_np = 3;
    expect_st(1, 0, "R7 revert after requalify");
    expect_np(exp_np, "R12 pulse count");

    ref_prio = {3'd2, 3'd2};
    cyc(6);
    expect_st(1, 0, "R6 equal code no switch");
    expect_np(exp_np, "R6 no pulse");

    ref_period = {16'd5, 16'd5};
    fault_blip(2'b11);
    cyc(3);
    expect_st(1, 1, "R11 holdover keeps index");
    cyc(30);
    exp_np = 4;
    expect_st(0, 0, "R5 tie picks lower index");

    sel_mode = 2'd2;
    ref_prio = {3'd1, 3'd2};
    cyc(4);
    expect_st(0, 0, "R8 stays on usable");
    fault_blip(2'b10);
    cyc(30);
    expect_st(0, 0, "R8 no revert");
    expect_np(exp_np, "R8 no pulse");

    ref_fault[0] = 1'b1;
    cyc(3);
    exp_np = 5;
    expect_st(1, 0, "R9 switch on loss");
    ref_fault[0] = 1'b0;
    cyc(30);
    expect_st(1, 0, "R9 stays after other returns");

    ref_fault = 2'b11;
    cyc(3);
    expect_st(1, 1, "R11 non-revertive holdover");

    sel_mode   = 2'd0;
    manual_sel = 1'b0;
    cyc(2);
    exp_np = 6;
    expect_st(0, 1, "R10 manual picks unusable");
    ref_fault[0] = 1'b0;
    cyc(30);
    expect_st(0, 0, "R10 holdover clears");
    manual_sel = 1'b1;
    cyc(2);
    exp_np = 7;
    expect_st(1, 1, "R10 manual to faulted input");

    sel_mode   = 2'd3;
    manual_sel = 1'b0;
    cyc(2);
    exp_np = 8;
    expect_st(0, 0, "R13 code 3 is manual");
    expect_np(exp_np, "R12 total pulses");

    cyc(2);
    finish_run();
  end

endmodule